// File: doc/BRIEF.md
# Current-Level Interrupt Mask

This block sits between the pending interrupt sources of an interrupt controller and the interrupt input of a processor core. Each source comes with a programmed priority level. The block picks the highest-priority eligible source, drives the core interrupt line and reports the winning level.

When the core performs an interrupt-acknowledge read, the block returns a vector that names the physical source. If automatic masking is enabled, the same acknowledge also raises a current-level threshold to the serviced source's level and keeps the previous threshold in a saved-level register. Any request at or below the threshold is then held off the core interrupt line.

Software can write either register directly. Writing the saved value back into the current level re-enables lower-priority requests. Writing a lower value and then issuing acknowledge reads polls for pending work.

Top module: `irq_level_mask`

## Requirements
- R1: After reset, the current level and the saved level are 0, `ack_valid` is low, and `core_irq` is low while nothing is pending.
- R2: With `auto_mask_en` high, a pending source is eligible only if its level is strictly greater than the current level. At reset, level-0 requests are therefore blocked.
- R3: With `auto_mask_en` low, every pending source is eligible whatever its level.
- R4: `core_irq` is high in the same cycle as any eligible source. `irq_level` gives the highest eligible level, and among sources at that level the lowest index wins. Source i's level occupies bits [3i+2:3i] of `req_levels`.
- R5: One cycle after `ack_rd` is sampled, `ack_valid` is high for one cycle. `ack_vector` is then 64 plus the index of the source that was winning at the sampling edge.
- R6: An acknowledge with no eligible source returns vector 24 and leaves both level registers unchanged.
- R7: An acknowledge with `auto_mask_en` high and an eligible winner loads the current level with the winner's level and the saved level with the old current level. Both are visible in the cycle where `ack_valid` is high.
- R8: An acknowledge with `auto_mask_en` low leaves both level registers unchanged.
- R9: A software write to either level register takes effect one cycle later. In a cycle that also holds a loading acknowledge (R7), the acknowledge update wins over both writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_mask_en | input | 1 | Enables level comparison and automatic loading |
| req_pending | input | 8 | Pending flag per source |
| req_levels | input | 24 | Priority level per source, 3 bits each |
| ack_rd | input | 1 | Interrupt-acknowledge read strobe |
| cur_wr_en | input | 1 | Software write to the current level |
| cur_wr_data | input | 3 | Value for the current-level write |
| sav_wr_en | input | 1 | Software write to the saved level |
| sav_wr_data | input | 3 | Value for the saved-level write |
| cur_level | output | 3 | Current-level threshold |
| sav_level | output | 3 | Saved-level register |
| core_irq | output | 1 | Interrupt request to the core |
| irq_level | output | 3 | Level of the winning eligible source |
| ack_valid | output | 1 | Acknowledge result strobe |
| ack_vector | output | 8 | Vector returned by the acknowledge |

## Verification
`core_irq` and `irq_level` are combinational. The bench drives them at a falling edge and samples them at the next falling edge.

An acknowledge strobed at a falling edge is captured at the following rising edge. Its vector and both updated level registers are all due at the falling edge after that, which is the edge where `ack_valid` is high. The scoreboard monitor pops and compares only on that strobe.

Software writes are checked one full cycle after the strobe. In each test, the bench predicts values from its own model of the winner and the register updates.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
  localparam int unsigned DEF_LVL_W = 3;
  localparam int unsigned DEF_VEC_W = 8;

  // Eligibility rule: pending, and either the comparison is bypassed or the level beats the threshold.
  function automatic logic lvl_passes(input logic pend, input int unsigned lvl,
                                      input int unsigned thr, input logic cmp_en);
    return pend && (!cmp_en || (lvl > thr));
  endfunction

  // Vector for a source index.
  function automatic int unsigned vector_calc(input int unsigned base, input int unsigned idx);
    return base + idx;
  endfunction

  typedef enum logic [1:0] {
    ACK_NONE  = 2'd0,
    ACK_HOLD  = 2'd1,
    ACK_LOAD  = 2'd2
  } ack_kind_e;
endpackage

// File: rtl/irq_lvl_filter.sv
module irq_lvl_filter import irq_lvl_pkg::*; #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned LVL_W   = DEF_LVL_W
) (
  input  logic [NUM_SRC-1:0]       pending,
  input  logic [NUM_SRC*LVL_W-1:0] levels,
  input  logic [LVL_W-1:0]         threshold,
  input  logic                     cmp_en,
  output logic [NUM_SRC-1:0]       eligible
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_comb begin
      eligible[g] = lvl_passes(pending[g], int'(levels[g*LVL_W +: LVL_W]),
                               int'(threshold), cmp_en);
    end
  end
endmodule

// File: rtl/irq_lvl_arbiter.sv
module irq_lvl_arbiter #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned LVL_W   = 3,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       eligible,
  input  logic [NUM_SRC*LVL_W-1:0] levels,
  output logic                     found,
  output logic [IDX_W-1:0]         win_idx,
  output logic [LVL_W-1:0]         win_lvl
);
  // Scan upward. A strictly greater level replaces the current best, so ties keep the lower index.
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (eligible[i] && (!found || (levels[i*LVL_W +: LVL_W] > win_lvl))) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = levels[i*LVL_W +: LVL_W];
      end
    end
  end

  // R4: the reported winner is itself eligible and carries the reported level
  assert_winner_eligible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (eligible[win_idx] && (levels[win_idx*LVL_W +: LVL_W] == win_lvl)));
endmodule

// File: rtl/irq_lvl_regs.sv
module irq_lvl_regs #(
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_load,
  input  logic [LVL_W-1:0] hw_level,
  input  logic             cur_we,
  input  logic [LVL_W-1:0] cur_wd,
  input  logic             sav_we,
  input  logic [LVL_W-1:0] sav_wd,
  output logic [LVL_W-1:0] cur_q,
  output logic [LVL_W-1:0] sav_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      sav_q <= '0;
    end else if (hw_load) begin
      cur_q <= hw_level;
      sav_q <= cur_q;
    end else begin
      if (cur_we) cur_q <= cur_wd;
      if (sav_we) sav_q <= sav_wd;
    end
  end

  // R7: a loading acknowledge moves the old threshold to the saved register
  assert_load_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hw_load |=> (cur_q == $past(hw_level)) && (sav_q == $past(cur_q)));
  // R8: without a load or a write, the current level holds
  assert_cur_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_load && !cur_we) |=> $stable(cur_q));
  // R9: a software write without a load lands next cycle
  assert_sw_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_load && sav_we) |=> (sav_q == $past(sav_wd)));
endmodule

// File: rtl/irq_level_mask.sv
module irq_level_mask import irq_lvl_pkg::*; #(
  parameter int unsigned NUM_SRC  = 8,
  parameter int unsigned LVL_W    = DEF_LVL_W,
  parameter int unsigned VEC_W    = DEF_VEC_W,
  parameter int unsigned VEC_BASE = 64,
  parameter int unsigned VEC_SPUR = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     auto_mask_en,
  input  logic [NUM_SRC-1:0]       req_pending,
  input  logic [NUM_SRC*LVL_W-1:0] req_levels,
  input  logic                     ack_rd,
  input  logic                     cur_wr_en,
  input  logic [LVL_W-1:0]         cur_wr_data,
  input  logic                     sav_wr_en,
  input  logic [LVL_W-1:0]         sav_wr_data,
  output logic [LVL_W-1:0]         cur_level,
  output logic [LVL_W-1:0]         sav_level,
  output logic                     core_irq,
  output logic [LVL_W-1:0]         irq_level,
  output logic                     ack_valid,
  output logic [VEC_W-1:0]         ack_vector
);
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] eligible;
  logic               found;
  logic [IDX_W-1:0]   win_idx;
  logic [LVL_W-1:0]   win_lvl;
  ack_kind_e          ack_kind;
  logic               level_load;

  irq_lvl_filter #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_filter (
    .pending(req_pending), .levels(req_levels), .threshold(cur_level),
    .cmp_en(auto_mask_en), .eligible(eligible)
  );

  irq_lvl_arbiter #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .eligible(eligible), .levels(req_levels),
    .found(found), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  // Classify the acknowledge of this cycle.
  always_comb begin
    if (!ack_rd)                     ack_kind = ACK_NONE;
    else if (found && auto_mask_en)  ack_kind = ACK_LOAD;
    else                             ack_kind = ACK_HOLD;
  end
  assign level_load = (ack_kind == ACK_LOAD);

  irq_lvl_regs #(.LVL_W(LVL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .hw_load(level_load), .hw_level(win_lvl),
    .cur_we(cur_wr_en), .cur_wd(cur_wr_data), .sav_we(sav_wr_en), .sav_wd(sav_wr_data),
    .cur_q(cur_level), .sav_q(sav_level)
  );

  assign core_irq  = found;
  assign irq_level = win_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid  <= 1'b0;
      ack_vector <= '0;
    end else begin
      ack_valid <= (ack_kind != ACK_NONE);
      if (ack_kind != ACK_NONE) begin
        ack_vector <= found ? VEC_W'(vector_calc(VEC_BASE, int'(win_idx)))
                            : VEC_W'(VEC_SPUR);
      end
    end
  end

  // R2: with masking on, the core never sees a request at or below the threshold
  assert_irq_above_thr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mask_en && core_irq) |-> (irq_level > cur_level));
  // R5: the result strobe follows an acknowledge by exactly one cycle
  assert_ack_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd |=> ack_valid);
  // R6: an acknowledge with nothing eligible yields the spurious vector
  assert_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !core_irq) |=> (ack_vector == VEC_W'(VEC_SPUR)));
  // R8: an acknowledge with masking off changes neither register unless written
  assert_off_no_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !auto_mask_en && !cur_wr_en && !sav_wr_en) |=> ($stable(cur_level) && $stable(sav_level)));
endmodule

// File: tb/tb_irq_level_mask.sv
module tb_irq_level_mask;
  localparam int NS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_mask_en = 1'b1;
  logic [NS-1:0] req_pending = '0;
  logic [NS*3-1:0] req_levels = '0;
  logic ack_rd = 1'b0;
  logic cur_wr_en = 1'b0, sav_wr_en = 1'b0;
  logic [2:0] cur_wr_data = '0, sav_wr_data = '0;
  logic [2:0] cur_level, sav_level, irq_level;
  logic core_irq, ack_valid;
  logic [7:0] ack_vector;

  always #10 clk = ~clk;

  irq_level_mask dut (
    .clk(clk), .rst_n(rst_n), .auto_mask_en(auto_mask_en), .req_pending(req_pending),
    .req_levels(req_levels), .ack_rd(ack_rd), .cur_wr_en(cur_wr_en), .cur_wr_data(cur_wr_data),
    .sav_wr_en(sav_wr_en), .sav_wr_data(sav_wr_data), .cur_level(cur_level), .sav_level(sav_level),
    .core_irq(core_irq), .irq_level(irq_level), .ack_valid(ack_valid), .ack_vector(ack_vector)
  );

  int n_checks = 0;
  int n_fail = 0;
  logic [2:0] m_cur = 0, m_sav = 0;
  logic [2:0] m_lvl [NS];
  logic m_pend [NS];

  typedef struct {
    logic [7:0] vec;
    logic [2:0] cur;
    logic [2:0] sav;
    string      tag;
  } exp_t;
  exp_t sb[$];

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_win(output bit f, output int idx, output int lv);
    f = 0; idx = 0; lv = 0;
    for (int i = 0; i < NS; i++) begin
      if (m_pend[i] && (!auto_mask_en || m_lvl[i] > m_cur)) begin
        if (!f || m_lvl[i] > lv) begin
          f = 1; idx = i; lv = m_lvl[i];
        end
      end
    end
  endtask

  task automatic apply();
    for (int i = 0; i < NS; i++) begin
      req_pending[i] = m_pend[i];
      req_levels[i*3 +: 3] = m_lvl[i];
    end
  endtask

  task automatic check_irq(input string tag);
    bit f; int idx; int lv;
    model_win(f, idx, lv);
    @(negedge clk);
    chk({tag, " core_irq"}, int'(core_irq), int'(f));
    if (f) chk({tag, " irq_level"}, int'(irq_level), lv);
  endtask

  // Driver: predict, push, strobe. Optional concurrent write to the current level.
  task automatic do_ack(input string tag, input bit wr, input logic [2:0] wv);
    bit f; int idx; int lv;
    exp_t e;
    model_win(f, idx, lv);
    e.tag = tag;
    e.vec = f ? 8'(64 + idx) : 8'd24;
    if (f && auto_mask_en) begin
      m_sav = m_cur;
      m_cur = 3'(lv);
    end else if (wr) begin
      m_cur = wv;
    end
    e.cur = m_cur;
    e.sav = m_sav;
    sb.push_back(e);
    ack_rd = 1'b1;
    cur_wr_en = wr;
    cur_wr_data = wv;
    @(negedge clk);
    ack_rd = 1'b0;
    cur_wr_en = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: compare on each result strobe.
  always @(negedge clk) begin
    if (rst_n && ack_valid) begin
      if (sb.size() == 0) begin
        chk("R5 unexpected ack_valid", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " vector"}, int'(ack_vector), int'(e.vec));
        chk({e.tag, " cur_level"}, int'(cur_level), int'(e.cur));
        chk({e.tag, " sav_level"}, int'(sav_level), int'(e.sav));
      end
    end
  end

  task automatic sw_write(input bit to_cur, input logic [2:0] v, input string tag);
    if (to_cur) begin cur_wr_en = 1; cur_wr_data = v; m_cur = v; end
    else        begin sav_wr_en = 1; sav_wr_data = v; m_sav = v; end
    @(negedge clk);
    cur_wr_en = 0; sav_wr_en = 0;
    @(negedge clk);
    chk({tag, " cur_level"}, int'(cur_level), int'(m_cur));
    chk({tag, " sav_level"}, int'(sav_level), int'(m_sav));
  endtask

  initial begin
    for (int i = 0; i < NS; i++) begin m_lvl[i] = 0; m_pend[i] = 0; end
    apply();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 cur_level", int'(cur_level), 0);
    chk("R1 sav_level", int'(sav_level), 0);
    chk("R1 ack_valid", int'(ack_valid), 0);
    chk("R1 core_irq", int'(core_irq), 0);

    // R2: level-0 request blocked at reset threshold
    m_pend[3] = 1; m_lvl[3] = 0; apply();
    check_irq("R2 level0 blocked");
    m_lvl[3] = 2; apply();
    check_irq("R2 level2 passes");

    // R4: highest level wins, tie to lowest index
    m_pend[1] = 1; m_lvl[1] = 5; m_pend[6] = 1; m_lvl[6] = 5;
    m_pend[2] = 1; m_lvl[2] = 3; apply();
    check_irq("R4 tie");
    // R5 R7: acknowledge loads levels
    do_ack("R5 R7 ack src1", 0, 0);
    check_irq("R2 after raise");
    m_pend[4] = 1; m_lvl[4] = 7; apply();
    do_ack("R7 ack src4", 0, 0);
    // R6: nothing eligible
    do_ack("R6 spurious", 0, 0);

    // R9: restore saved value into the current level
    sw_write(1, m_sav, "R9 restore");
    check_irq("R9 level7 visible");
    m_pend[4] = 0; apply();
    sw_write(1, 3'd0, "R9 lower");
    do_ack("R4 R7 poll tie", 0, 0);
    sw_write(0, 3'd3, "R9 saved write");

    // R9: write to current level collides with a loading acknowledge
    sw_write(1, 3'd0, "R9 lower again");
    do_ack("R9 ack beats write", 1, 3'd6);
    // Non-loading acknowledge lets the write through
    do_ack("R6 R9 spurious with write", 1, 3'd1);

    // R3 R8: masking disabled
    auto_mask_en = 0;
    for (int i = 0; i < NS; i++) m_pend[i] = 0;
    m_pend[0] = 1; m_lvl[0] = 0; apply();
    check_irq("R3 bypass level0");
    do_ack("R8 ack disabled", 0, 0);
    m_pend[0] = 0; apply();
    do_ack("R6 R8 spurious disabled", 0, 0);

    repeat (3) @(negedge clk);
    chk("R5 scoreboard drained", sb.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule